// File: doc/BRIEF.md
# Wired-OR Peripheral Register Bus

This block connects a processor-side bus master to a set of small peripheral register banks over a shared 16-bit address and 16-bit data path. Every peripheral owns a 16-byte window chosen by a base tag on the upper twelve address bits. Inside that window sit eight 16-bit registers that can be written and read either as whole halfwords or as single bytes.

A transfer is qualified by a select strobe, together with a read strobe, a write strobe, or both. Each bank decodes its own hit and registers its own read data. A bank that is not hit by an accepted read returns zero, so the fabric merges the returned words with a plain OR tree rather than a multiplexer. Writes land on the clock edge where they are presented. Read data appears in the following cycle.

Top module: `wob_fabric`

## Requirements
- R1: A bank responds only when addr_i[15:4] equals its 12-bit base tag. addr_i[3:1] picks one of its eight registers.
- R2: A halfword write (sel_i, wr_i and wide_i high at a clock edge) stores all of wdata_i in the addressed register on that edge. addr_i[0] is ignored.
- R3: A byte write (wide_i low) with addr_i[0]=0 stores wdata_i[7:0] into bits 7:0. With addr_i[0]=1 it stores wdata_i[15:8] into bits 15:8. The other byte of the register keeps its value.
- R4: A halfword read accepted at a clock edge (sel_i and rd_i high) puts the full register value on rdata_o in the cycle after that edge.
- R5: A byte read returns the addressed byte in its own lane position: bits 7:0 when addr_i[0]=0, bits 15:8 when addr_i[0]=1. The other lane is zero.
- R6: rdata_o is zero in every cycle that does not directly follow an accepted read that hit a bank.
- R7: An access to an address outside every window reads as zero and changes no register.
- R8: rd_i or wr_i with sel_i low has no effect. The output stays zero and no register changes.
- R9: A read and a write in the same cycle to the same register commit the write, and the read returns the value held before that write.
- R10: While rst_ni is low, and right after it rises, every register and rdata_o are zero.
- R11: The base tags are distinct, so at most one bank is hit for any address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Transfer select strobe |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wide_i | input | 1 | 1 = halfword transfer, 0 = byte transfer |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 16 | Write data, byte data on its own lane |
| rdata_o | output | 16 | OR-merged read data, valid the cycle after a read |

## Verification
A read and a write can fall in the same cycle on the same register, and a byte write can coincide with a byte read of the other lane of that register. The bench raises both strobes together, first in directed cycles and then in a long random run. Addresses in that run are biased into the windows and onto their edges. A behavioural model evaluates the read against the state before the write and then applies the write. Its prediction is compared with rdata_o on every clock, and a later full readback catches any lane corruption.

// File: rtl/wob_pkg.sv
package wob_pkg;
  localparam int unsigned BUS_AW    = 16;
  localparam int unsigned BUS_DW    = 16;
  localparam int unsigned BUS_BYTES = BUS_DW / 8;
  localparam int unsigned LANE_W    = $clog2(BUS_BYTES);

  typedef logic [BUS_DW-1:0]    word_t;
  typedef logic [BUS_BYTES-1:0] be_t;

  // byte enables for one transfer
  function automatic be_t lane_enables(input logic wide, input logic [LANE_W-1:0] lane);
    be_t be;
    if (wide) be = '1;
    else begin
      be = '0;
      be[lane] = 1'b1;
    end
    return be;
  endfunction

  function automatic word_t expand_be(input be_t be);
    word_t m;
    for (int b = 0; b < int'(BUS_BYTES); b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/wob_decoder.sv
module wob_decoder #(
  parameter int unsigned N_SLV = 3,
  parameter int unsigned TAG_W = 12,
  parameter logic [N_SLV*TAG_W-1:0] BASES = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] tag_i,
  output logic [N_SLV-1:0] hit_o
);
  for (genvar k = 0; k < N_SLV; k++) begin : g_cmp
    assign hit_o[k] = (tag_i == BASES[k*TAG_W +: TAG_W]);
  end

  p_one_hit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o))
    else $error("overlapping bank windows");
endmodule

// File: rtl/wob_reg_slave.sv
module wob_reg_slave
  import wob_pkg::*;
#(
  parameter int unsigned WIN_BITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hit_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic                wide_i,
  input  logic [WIN_BITS-1:0] off_i,
  input  word_t               wdata_i,
  output word_t               rdata_o
);
  localparam int unsigned N_REGS = (2 ** WIN_BITS) / BUS_BYTES;
  localparam int unsigned IDX_W  = WIN_BITS - LANE_W;

  logic [IDX_W-1:0]  idx;
  logic [LANE_W-1:0] lane;
  be_t               be;
  logic              wr_en, rd_en;
  logic [N_REGS-1:0][BUS_DW-1:0] regs_q;
  word_t             rdata_d, rdata_q;

  assign idx   = off_i[WIN_BITS-1:LANE_W];
  assign lane  = off_i[LANE_W-1:0];
  assign be    = lane_enables(wide_i, lane);
  assign wr_en = hit_i & wr_i;
  assign rd_en = hit_i & rd_i;

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
      logic lane_we;
      assign lane_we = wr_en && (idx == IDX_W'(r)) && be[b];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      regs_q[r][b*8 +: 8] <= '0;
        else if (lane_we) regs_q[r][b*8 +: 8] <= wdata_i[b*8 +: 8];
      end

      p_lane_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en && (idx == IDX_W'(r)) && be[b]) |=> $stable(regs_q[r][b*8 +: 8]))
        else $error("untargeted byte lane changed");
    end
  end

  // zero unless this bank is being read: required by the OR merge
  always_comb begin
    rdata_d = '0;
    if (rd_en) rdata_d = regs_q[idx] & expand_be(be);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  p_idle_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_i && rd_i) |=> (rdata_o == '0))
    else $error("unselected bank drove read data");

  p_read_old_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && rd_i && wide_i) |=> (rdata_o == $past(regs_q[idx])))
    else $error("read did not return pre-write value");
endmodule

// File: rtl/wob_or_merge.sv
module wob_or_merge
  import wob_pkg::*;
#(
  parameter int unsigned N_SLV = 3
) (
  input  logic [N_SLV-1:0][BUS_DW-1:0] rdata_i,
  output word_t                        rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < int'(N_SLV); k++) rdata_o |= rdata_i[k];
  end
endmodule

// File: rtl/wob_fabric.sv
module wob_fabric
  import wob_pkg::*;
#(
  parameter int unsigned N_SLV    = 3,
  parameter int unsigned WIN_BITS = 4,
  parameter logic [N_SLV*(BUS_AW-WIN_BITS)-1:0] BASES =
    {12'h7F0, 12'h020, 12'h010}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BUS_DW-1:0] wdata_i,
  output logic [BUS_DW-1:0] rdata_o
);
  localparam int unsigned TAG_W = BUS_AW - WIN_BITS;

  logic [N_SLV-1:0] addr_hit, slv_hit;
  logic [N_SLV-1:0][BUS_DW-1:0] slv_rdata;

  wob_decoder #(.N_SLV(N_SLV), .TAG_W(TAG_W), .BASES(BASES)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (addr_i[BUS_AW-1:WIN_BITS]),
    .hit_o  (addr_hit)
  );

  assign slv_hit = addr_hit & {N_SLV{sel_i}};

  for (genvar k = 0; k < N_SLV; k++) begin : g_slv
    wob_reg_slave #(.WIN_BITS(WIN_BITS)) u_slv (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (slv_hit[k]),
      .rd_i    (rd_i),
      .wr_i    (wr_i),
      .wide_i  (wide_i),
      .off_i   (addr_i[WIN_BITS-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (slv_rdata[k])
    );
  end

  wob_or_merge #(.N_SLV(N_SLV)) u_merge (
    .rdata_i (slv_rdata),
    .rdata_o (rdata_o)
  );

  p_unmapped_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i && !(|addr_hit)) |=> (rdata_o == '0))
    else $error("unmapped read returned data");

  p_no_sel_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (rdata_o == '0))
    else $error("read data without select");

  p_byte_lane_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i && !wide_i) |=> ($countones({|rdata_o[15:8], |rdata_o[7:0]}) <= 1))
    else $error("byte read drove both lanes");
endmodule

// File: tb/wob_fabric_bench.sv
`timescale 1ns/1ps
module wob_fabric_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0, wide_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [15:0] rdata_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [11:0] bases [0:2] = '{12'h010, 12'h020, 12'h7F0};
  logic [15:0] mem [0:2][0:7];

  always #2.5 clk_i = ~clk_i;

  wob_fabric #(.N_SLV(3), .WIN_BITS(4), .BASES({12'h7F0, 12'h020, 12'h010})) u_wob_fabric (
    .clk_i, .rst_ni, .sel_i, .rd_i, .wr_i, .wide_i, .addr_i, .wdata_i, .rdata_o
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata_o actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int find(input logic [15:0] a);
    for (int k = 0; k < 3; k++) if (a[15:4] == bases[k]) return k;
    return -1;
  endfunction

  // one bus cycle: drive after negedge, model it, compare at next negedge
  task automatic cyc(input bit s, input bit r, input bit w, input bit wd,
                     input logic [15:0] a, input logic [15:0] d, input string tag);
    logic [15:0] expv;
    int k, ri;
    sel_i = s; rd_i = r; wr_i = w; wide_i = wd; addr_i = a; wdata_i = d;
    expv = '0;
    k  = find(a);
    ri = int'(a[3:1]);
    if (s && r && k >= 0)
      expv = wd ? mem[k][ri] : (a[0] ? {mem[k][ri][15:8], 8'h00} : {8'h00, mem[k][ri][7:0]});
    if (s && w && k >= 0) begin
      if (wd)        mem[k][ri] = d;
      else if (a[0]) mem[k][ri][15:8] = d[15:8];
      else           mem[k][ri][7:0] = d[7:0];
    end
    @(negedge clk_i);
    check(tag, rdata_o, expv);
  endtask

  task automatic readback(input string tag);
    for (int k = 0; k < 3; k++)
      for (int r = 0; r < 8; r++)
        cyc(1, 1, 0, 1, {bases[k], 3'(r), 1'b0}, 16'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) for (int r = 0; r < 8; r++) mem[k][r] = '0;
    repeat (3) begin
      @(negedge clk_i);
      check("R10 in reset", rdata_o, 16'h0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 after reset", rdata_o, 16'h0);
    readback("R10 registers cleared");

    // R2/R4 halfword writes, odd address bit ignored on some
    for (int k = 0; k < 3; k++)
      for (int r = 0; r < 8; r++)
        cyc(1, 0, 1, 1, {bases[k], 3'(r), 1'(r)}, 16'(16'h1000 * (k + 1) + 16'h0101 * r + 16'h0a05), "R2");
    readback("R4 halfword read");

    // R1 window edges
    cyc(1, 0, 1, 1, 16'h010E, 16'hBEEF, "R1");
    cyc(1, 0, 1, 1, 16'h0110, 16'hDEAD, "R1");
    cyc(1, 0, 1, 1, 16'h00FE, 16'hDEAD, "R1");
    cyc(1, 1, 0, 1, 16'h010E, 16'h0, "R1");
    cyc(1, 1, 0, 1, 16'h0200, 16'h0, "R1");
    cyc(1, 1, 0, 1, 16'h7FFE, 16'h0, "R1");

    // R3/R5 byte lanes
    cyc(1, 0, 1, 0, 16'h0202, 16'h55AA, "R3 lane0");
    cyc(1, 0, 1, 0, 16'h0205, 16'hC3FF, "R3 lane1");
    cyc(1, 1, 0, 0, 16'h0202, 16'h0, "R5 lane0");
    cyc(1, 1, 0, 0, 16'h0203, 16'h0, "R5 lane1");
    cyc(1, 1, 0, 1, 16'h0202, 16'h0, "R3 other lane kept");
    cyc(1, 1, 0, 1, 16'h0204, 16'h0, "R3 other lane kept");

    // R6 idle after reads
    cyc(1, 1, 0, 1, 16'h0100, 16'h0, "R4");
    cyc(0, 0, 0, 1, 16'h0100, 16'h0, "R6");
    cyc(1, 0, 0, 1, 16'h0100, 16'h0, "R6");

    // R7 unmapped
    cyc(1, 0, 1, 1, 16'h0030, 16'hFFFF, "R7");
    cyc(1, 0, 1, 0, 16'hFFF1, 16'hFFFF, "R7");
    cyc(1, 1, 0, 1, 16'h0030, 16'h0, "R7");
    cyc(1, 1, 0, 0, 16'h8001, 16'h0, "R7");
    readback("R7 no side effect");

    // R8 strobes without select
    cyc(0, 0, 1, 1, 16'h0100, 16'h1234, "R8");
    cyc(0, 1, 0, 1, 16'h0100, 16'h0, "R8");
    cyc(0, 1, 1, 0, 16'h7F03, 16'h9999, "R8");
    readback("R8 no side effect");

    // R9 read and write together
    cyc(1, 1, 1, 1, 16'h0206, 16'hA1B2, "R9");
    cyc(1, 1, 1, 1, 16'h0206, 16'hC3D4, "R9");
    cyc(1, 1, 1, 0, 16'h0207, 16'h7700, "R9");
    cyc(1, 1, 0, 1, 16'h0206, 16'h0, "R9");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int pick;
      logic [15:0] a;
      pick = int'($urandom % 4);
      a = (pick < 3) ? {bases[pick], 4'($urandom)} : 16'($urandom);
      cyc(($urandom % 8) != 0, 1'($urandom), 1'($urandom), 1'($urandom), a, 16'($urandom), "R1 random");
    end
    readback("R3 final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule